// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line Filter

This block receives asynchronous serial frames on a single input line. A sample tick, running at 2^OSR_LOG2 times the bit rate, paces all line timing. Before start detection the line is synchronised and then filtered, so that short pulses are removed. A falling edge that survives the filter starts a frame. The start bit is confirmed at its midpoint. Each data bit, the optional parity bit and exactly one stop bit are then sampled near their centres, least significant data bit first.

When the stop bit has been sampled, the block does one of three things with the frame. It loads the word into a one-entry receive buffer, or it records a break, or it records an overrun and drops the word. Parity and framing errors are kept as sticky flags. All status bits are ORed into a single registered interrupt request. A host empties the buffer with a data-read strobe and clears the error flags with a status-read strobe.

Top module: `serial_rx_core`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rx_data` is zero and every flag output is zero, including `irq`.
- R2: A low pulse on `rxd` that lasts fewer than two sample ticks never starts a frame. No flag rises and the buffer does not change.
- R3: When the line is low at the falling edge but high at the start-bit midpoint (half a bit period later), the receiver treats it as a false start and returns to idle. Nothing is loaded and no flag rises.
- R4: `wlen` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant first and are sampled mid-bit. Unused upper bits of `rx_data` read zero.
- R5: When `par_en` is 1, a parity bit follows the data. `par_odd`=1 requires an odd count of ones over data and parity, and 0 requires an even count. On a mismatch `err_parity` is set and the word is still loaded.
- R6: The receiver samples exactly one stop bit. A new start bit may follow the stop bit with no idle time, and both frames are received.
- R7: If the stop bit samples low and the frame is not a break, `err_frame` is set and the word is still loaded.
- R8: If the data bits, the parity bit (when enabled) and the stop bit all sample low, `err_break` is set and the buffer is not loaded. No new start is searched for until the line has returned high.
- R9: If a frame completes while `rx_full` is set, `err_overrun` is set, `rx_data` keeps the older word and the new word is discarded.
- R10: A one-cycle `rd_data` pulse clears `rx_full`. A one-cycle `rd_status` pulse clears all four error flags. The error flags stay set until that pulse arrives.
- R11: `irq` is high exactly when `rx_full` or any error flag is high.
- R12: `rx_full` and the error flags change for a frame only after its stop bit has been sampled. They are still clear early in the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| smp_tick | input | 1 | One-cycle sample enable at 2^OSR_LOG2 times the bit rate |
| wlen | input | 2 | Word length select (0..3 for 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| rd_data | input | 1 | Read strobe for the receive buffer |
| rd_status | input | 1 | Read strobe that clears the error flags |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Buffer holds an unread word |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |
| err_break | output | 1 | Sticky break detected |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the one that separates a break from a framing error and from a spurious start. When the line stays low past the stop bit, the receiver must not slip into a new frame while it waits. A stop bit that is low but shorter than usual must turn into a discarded false start rather than a phantom word. The stimulus holds the line low for twelve bit times and then sends a clean frame, which shows that only the break was recorded. The framing-error frame lowers the stop bit for three quarters of a bit, so that the trailing low is caught as a false start. The overrun case suppresses reads on one frame so that the next completes into a full buffer.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int RX_MAXW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rx_state_t;

  typedef struct packed {
    logic [RX_MAXW-1:0] data;
    logic               par_err;
    logic               frm_err;
    logic               brk;
  } rx_frame_t;
endpackage

// File: rtl/rx_line_filter.sv
module rx_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  output logic filt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  // The filtered level follows only after FILT_LEN equal tick samples
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '1;
      filt <= 1'b1;
    end else if (tick) begin
      hist <= {hist[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist)       filt <= 1'b1;
      else if (~|hist) filt <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OSR_LOG2 = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      filt,
  input  logic [1:0] wlen,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      done,
  output rx_frame_t frame
);
  localparam int OS   = 1 << OSR_LOG2;
  localparam int HALF = OS / 2;
  localparam logic [OSR_LOG2-1:0] CNT_END  = OSR_LOG2'(OS - 1);
  localparam logic [OSR_LOG2-1:0] CNT_HALF = OSR_LOG2'(HALF - 1);

  rx_state_t            st;
  logic [OSR_LOG2-1:0]  cnt;
  logic [2:0]           bidx;
  logic [2:0]           last_bit;
  logic [RX_MAXW-1:0]   shd;
  logic                 parb;
  logic                 brk_now;

  assign last_bit = 3'd4 + {1'b0, wlen};
  assign brk_now  = !filt && (shd == '0) && (!par_en || !parb);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shd   <= '0;
      parb  <= 1'b0;
      done  <= 1'b0;
      frame <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (!filt) begin
            st  <= ST_START;
            cnt <= '0;
          end
          ST_START: if (cnt == CNT_HALF) begin
            cnt <= '0;
            if (filt) st <= ST_IDLE;
            else begin
              st   <= ST_DATA;
              bidx <= '0;
              shd  <= '0;
              parb <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
          ST_DATA: if (cnt == CNT_END) begin
            cnt       <= '0;
            shd[bidx] <= filt;
            if (bidx == last_bit) st <= par_en ? ST_PAR : ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
          ST_PAR: if (cnt == CNT_END) begin
            cnt  <= '0;
            parb <= filt;
            st   <= ST_STOP;
          end else cnt <= cnt + 1'b1;
          ST_STOP: if (cnt == CNT_END) begin
            cnt           <= '0;
            done          <= 1'b1;
            frame.data    <= shd;
            frame.brk     <= brk_now;
            frame.frm_err <= !filt && !brk_now;
            frame.par_err <= par_en && !brk_now && (^{shd, parb, par_odd});
            st            <= brk_now ? ST_WAITHI : ST_IDLE;
          end else cnt <= cnt + 1'b1;
          ST_WAITHI: if (filt) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R12: a frame result appears only when the stop bit has just been sampled
  assert_done_after_stop_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st) == ST_STOP);

  // R8: while waiting for the line to rise after a break, no frame completes
  assert_break_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAITHI) |=> !done);
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import serial_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  rx_frame_t          frame,
  input  logic               rd_data,
  input  logic               rd_status,
  output logic [RX_MAXW-1:0] rx_data,
  output logic               rx_full,
  output logic               err_parity,
  output logic               err_frame,
  output logic               err_overrun,
  output logic               err_break,
  output logic               irq
);
  logic [RX_MAXW-1:0] n_data;
  logic n_full, n_pe, n_fe, n_ovr, n_brk, full_keep;

  always_comb begin
    full_keep = rx_full && !rd_data;
    n_full    = full_keep;
    n_data    = rx_data;
    n_pe      = err_parity  && !rd_status;
    n_fe      = err_frame   && !rd_status;
    n_ovr     = err_overrun && !rd_status;
    n_brk     = err_break   && !rd_status;
    if (done) begin
      if (frame.brk)      n_brk = 1'b1;
      else if (full_keep) n_ovr = 1'b1;
      else begin
        n_full = 1'b1;
        n_data = frame.data;
        n_pe   = n_pe || frame.par_err;
        n_fe   = n_fe || frame.frm_err;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      err_break   <= 1'b0;
      irq         <= 1'b0;
    end else begin
      rx_data     <= n_data;
      rx_full     <= n_full;
      err_parity  <= n_pe;
      err_frame   <= n_fe;
      err_overrun <= n_ovr;
      err_break   <= n_brk;
      irq         <= n_full || n_pe || n_fe || n_ovr || n_brk;
    end
  end

  assert_overrun_keeps_word_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> ($stable(rx_data) && rx_full));

  assert_read_empties_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !done) |=> !rx_full);

  assert_errors_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ((err_frame || err_parity) && !rd_status) |=> (err_frame || err_parity));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR_LOG2    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic       smp_tick,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       err_break,
  output logic       irq
);
  logic      filt;
  logic      done;
  rx_frame_t frame;

  rx_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_filter (
    .clk(clk), .rst(rst), .tick(smp_tick), .rxd(rxd), .filt(filt));

  rx_frame_fsm #(.OSR_LOG2(OSR_LOG2)) i_fsm (
    .clk(clk), .rst(rst), .tick(smp_tick), .filt(filt), .wlen(wlen),
    .par_en(par_en), .par_odd(par_odd), .done(done), .frame(frame));

  rx_status_regs i_status (
    .clk(clk), .rst(rst), .done(done), .frame(frame),
    .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
    .rx_full(rx_full), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .err_break(err_break), .irq(irq));

  assert_irq_combined_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (rx_full || err_parity || err_frame || err_overrun || err_break));
endmodule

// File: tb/test_serial_rx_core.sv
`timescale 1ns/1ps
module test_serial_rx_core;
  localparam int OS  = 16;
  localparam int BIT = OS * 2;

  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1, smp_tick = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, err_parity, err_frame, err_overrun, err_break, irq;

  int n_tests = 0, n_fail = 0;

  typedef struct {
    logic [7:0] d;
    logic full, pe, fe, ovr, brk, hold;
    string tag;
  } exp_t;
  exp_t q[$];

  serial_rx_core i_serial_rx_core (
    .clk(clk), .rst(rst), .rxd(rxd), .smp_tick(smp_tick), .wlen(wlen),
    .par_en(par_en), .par_odd(par_odd), .rd_data(rd_data), .rd_status(rd_status),
    .rx_data(rx_data), .rx_full(rx_full), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .err_break(err_break),
    .irq(irq));

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    smp_tick <= rst ? 1'b0 : ~smp_tick;
  end

  task automatic chk(input bit ok, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic expect_item(input logic [7:0] d, input logic full, pe, fe, ovr, brk,
                             input logic hold, input string tag);
    exp_t e;
    e.d = d; e.full = full; e.pe = pe; e.fe = fe; e.ovr = ovr; e.brk = brk;
    e.hold = hold; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit badp,
                            input int stop_clks, input int idle_clks, input bit early);
    logic p;
    p = par_odd;
    @(negedge clk) rxd = 1'b0;
    repeat (BIT - 1) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      p   = p ^ d[i];
      repeat (BIT) @(negedge clk);
    end
    if (par_en) begin
      rxd = badp ? ~p : p;
      repeat (BIT) @(negedge clk);
    end
    rxd = (stop_clks < BIT) ? 1'b0 : 1'b1;
    if (early) begin
      repeat (4) @(negedge clk);
      chk(!rx_full && !irq, $sformatf("R12 status early in stop bit: full=%0b irq=%0b exp 0 0",
          rx_full, irq));
      repeat (((stop_clks < BIT) ? stop_clks : BIT) - 4) @(negedge clk);
    end else repeat ((stop_clks < BIT) ? stop_clks : BIT) @(negedge clk);
    rxd = 1'b1;
    if (stop_clks < BIT) repeat (BIT - stop_clks) @(negedge clk);
    repeat (idle_clks) @(negedge clk);
  endtask

  // Monitor: compares each new status event against the scoreboard queue
  initial begin
    logic [4:0] prev, cur;
    exp_t e;
    prev = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        cur = {rx_full, err_parity, err_frame, err_overrun, err_break};
        if ((cur & ~prev) != 0) begin
          if (q.size() == 0) begin
            chk(1'b0, $sformatf("R2 unexpected event flags=%b exp none", cur));
          end else begin
            e = q.pop_front();
            chk({cur, irq} == {e.full, e.pe, e.fe, e.ovr, e.brk, 1'b1},
                $sformatf("%s flags full/pe/fe/ovr/brk/irq=%b exp %b", e.tag, {cur, irq},
                {e.full, e.pe, e.fe, e.ovr, e.brk, 1'b1}));
            if (e.full)
              chk(rx_data == e.d, $sformatf("%s data=%h exp %h", e.tag, rx_data, e.d));
            if (!e.hold) begin
              rd_data = 1'b1; rd_status = 1'b1;
              @(negedge clk);
              rd_data = 1'b0; rd_status = 1'b0;
              cur = {rx_full, err_parity, err_frame, err_overrun, err_break};
              chk(cur == 5'b0 && !irq, $sformatf("R10 after reads flags=%b irq=%0b exp 0 0",
                  cur, irq));
            end
          end
        end
        prev = cur;
      end
    end
  end

  initial begin
    #(4ns * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired, pending items=%0d exp 0", q.size());
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk({rx_data, rx_full, err_parity, err_frame, err_overrun, err_break, irq} == '0,
        $sformatf("R1 in reset data=%h flags=%b exp all 0", rx_data,
        {rx_full, err_parity, err_frame, err_overrun, err_break, irq}));
    rst = 1'b0;
    @(negedge clk);
    chk({rx_data, irq, rx_full} == '0, $sformatf("R1 after reset data=%h irq=%0b exp 0",
        rx_data, irq));
    repeat (3 * BIT) @(negedge clk);

    // R4: 8-bit words, no parity, R12 early check on the first
    expect_item(8'hA5, 1, 0, 0, 0, 0, 0, "R4 8-bit A5");
    send_frame(8'hA5, 8, 0, BIT, 2 * BIT, 1);
    expect_item(8'h3C, 1, 0, 0, 0, 0, 0, "R4 8-bit 3C");
    send_frame(8'h3C, 8, 0, BIT, 2 * BIT, 0);

    // R6: back to back with no idle after the single stop bit
    expect_item(8'h81, 1, 0, 0, 0, 0, 0, "R6 back-to-back 81");
    send_frame(8'h81, 8, 0, BIT, 0, 0);
    expect_item(8'h7E, 1, 0, 0, 0, 0, 0, "R6 back-to-back 7E");
    send_frame(8'h7E, 8, 0, BIT, 2 * BIT, 0);

    // R4: 5-bit words
    wlen = 2'd0;
    expect_item(8'h15, 1, 0, 0, 0, 0, 0, "R4 5-bit 15");
    send_frame(8'h15, 5, 0, BIT, 2 * BIT, 0);
    expect_item(8'h1F, 1, 0, 0, 0, 0, 0, "R4 5-bit 1F");
    send_frame(8'hFF, 5, 0, BIT, 2 * BIT, 0);

    // R5: 7-bit even parity, then 8-bit odd parity
    wlen = 2'd2; par_en = 1'b1; par_odd = 1'b0;
    expect_item(8'h55, 1, 0, 0, 0, 0, 0, "R5 even good");
    send_frame(8'h55, 7, 0, BIT, 2 * BIT, 0);
    expect_item(8'h2A, 1, 1, 0, 0, 0, 0, "R5 even bad");
    send_frame(8'h2A, 7, 1, BIT, 2 * BIT, 0);
    wlen = 2'd3; par_odd = 1'b1;
    expect_item(8'hC3, 1, 0, 0, 0, 0, 0, "R5 odd good");
    send_frame(8'hC3, 8, 0, BIT, 2 * BIT, 0);
    expect_item(8'h01, 1, 1, 0, 0, 0, 0, "R5 odd bad");
    send_frame(8'h01, 8, 1, BIT, 2 * BIT, 0);
    par_en = 1'b0;

    // R7: low stop bit, trailing low becomes a discarded false start
    expect_item(8'h5A, 1, 0, 1, 0, 0, 0, "R7 framing");
    send_frame(8'h5A, 8, 0, (3 * BIT) / 4, 3 * BIT, 0);

    // R8: break held for twelve bit times, then a clean frame
    expect_item(8'h00, 0, 0, 0, 0, 1, 0, "R8 break");
    @(negedge clk) rxd = 1'b0;
    repeat (12 * BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    expect_item(8'h33, 1, 0, 0, 0, 0, 0, "R8 after break");
    send_frame(8'h33, 8, 0, BIT, 2 * BIT, 0);

    // R9: overrun with the first word left unread
    expect_item(8'h11, 1, 0, 0, 0, 0, 1, "R9 first held");
    send_frame(8'h11, 8, 0, BIT, 2 * BIT, 0);
    expect_item(8'h11, 1, 0, 0, 1, 0, 0, "R9 overrun");
    send_frame(8'h22, 8, 0, BIT, 2 * BIT, 0);

    // R2: single-tick glitches
    for (int g = 0; g < 4; g++) begin
      @(negedge clk) rxd = 1'b0;
      repeat (2) @(negedge clk);
      rxd = 1'b1;
      repeat (BIT) @(negedge clk);
    end
    repeat (2 * BIT) @(negedge clk);
    chk(!rx_full && !irq, $sformatf("R2 glitches ignored full=%0b irq=%0b exp 0 0",
        rx_full, irq));

    // R3: low for five ticks, shorter than half a bit
    @(negedge clk) rxd = 1'b0;
    repeat (10) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    chk(!rx_full && !irq && rx_data == 8'h11,
        $sformatf("R3 false start full=%0b irq=%0b data=%h exp 0 0 11", rx_full, irq, rx_data));
    expect_item(8'h6D, 1, 0, 0, 0, 0, 0, "R3 frame after false start");
    send_frame(8'h6D, 8, 0, BIT, 4 * BIT, 0);

    chk(q.size() == 0, $sformatf("R4 pending items=%0d exp 0", q.size()));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule